// File: doc/BRIEF.md
# Successive Approximation ADC Sequencer

This block is the digital half of a 10-bit successive-approximation converter. A start strobe, taken while a machine-cycle enable is high, starts a conversion. The sequencer then drives a code to an external resistor-ladder DAC and reads one comparator bit. The comparator bit is high when the analog input is above the ladder voltage. The result is built one bit at a time, from the most significant bit down to the least. The same register that drives the ladder is also the readable result.

A conversion always takes the same number of enabled machine cycles. The ten bit trials are placed at fixed points inside that window, and the cycles after the last trial are idle padding. At the end, the block sets a sticky completion flag and sends a one-clock interrupt request. Because a machine-cycle enable paces the block, it can run from a system clock faster than the machine cycle.

The controller has two states. `ST_IDLE` waits for a start. `ST_CONV` counts enabled cycles and runs the trials. The transition START (`ST_IDLE` to `ST_CONV`) happens on an accepted start strobe. The transition FINISH (`ST_CONV` to `ST_IDLE`) happens on the last enabled cycle of the window. Synchronous reset forces `ST_IDLE` from either state.

Top module: `sar_adc_seq`

## Requirements
- R1: A start taken in `ST_IDLE` on a clock where `mc_en` is high clears `code` to 0 on that edge and raises `busy`.
- R2: Trial k (k = 0..9) sets bit 9-k of `code` to 1 on the enabled edge where the internal count equals 1+6k. Edge counting starts at 1 for the first enabled edge after the start edge, so trial k is applied on enabled edge 2+6k. The first trial therefore drives 0x200.
- R3: On its sampling edge (enabled edge 3+6k), a trial bit stays 1 if `cmp_hi` is 1 and is cleared if `cmp_hi` is 0. With an ideal comparator the final code is the largest code strictly below the input: 0 for input 0, otherwise min(input-1, 1023).
- R4: Trials run from MSB to LSB. After trial k has been sampled, bits 9..9-k hold their final values and all lower bits are 0.
- R5: `busy` stays high through enabled edge 61 and falls on enabled edge 62 after the start edge, which ends the conversion.
- R6: On the completing edge, `irq` goes high for exactly one clock and `done_flag` is set.
- R7: `done_flag` is sticky. Only `flag_clr` or reset clears it, and a new start leaves it as it is. When a set and a clear fall on the same edge, the set wins.
- R8: A start that arrives while `busy` is high, or while `mc_en` is low, is ignored.
- R9: While `mc_en` is low, the sequencer is frozen: `code`, `busy` and the cycle count hold.
- R10: Synchronous reset returns the block to `ST_IDLE` with `code`, `done_flag` and `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mc_en | input | 1 | Machine-cycle enable; advances the sequencer |
| start | input | 1 | Conversion start strobe |
| flag_clr | input | 1 | Clears the completion flag |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is above the ladder voltage |
| code | output | 10 | Ladder DAC code and conversion result |
| busy | output | 1 | High while a conversion runs |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | One-clock completion interrupt request |

## Verification
The hardest case to reach is the one where a correct-looking final result hides a wrong intermediate trial. A slip in trial order or trial timing can still reach the right code for many inputs. To catch this, the bench sweeps every input level from 0 to 1024. For each trial it checks the ladder code on both the apply edge and the sample edge, against a prefix of the expected result that the bench computes itself. Some conversions run with an idle clock before every enabled edge, to test that the block freezes while `mc_en` is low. Other conversions inject a start in the middle of the window, or a clear that lands on the completing edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_e;
endpackage

// File: rtl/sar_timer.sv
// Counts enabled machine cycles within a conversion window and decodes
// the apply / sample point of each bit trial.
module sar_timer #(
    parameter int NBITS        = 10,
    parameter int CONV_CYCLES  = 62,
    parameter int FIRST_TRIAL  = 2,
    parameter int TRIAL_STRIDE = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic             last,
    output logic [NBITS-1:0] apply_vec,
    output logic [NBITS-1:0] sample_vec
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = (cnt_q == CW'(CONV_CYCLES - 1));

    for (genvar k = 0; k < NBITS; k++) begin : g_trial
        assign apply_vec[k]  = (cnt_q == CW'(FIRST_TRIAL - 1 + TRIAL_STRIDE * k));
        assign sample_vec[k] = (cnt_q == CW'(FIRST_TRIAL + TRIAL_STRIDE * k));
    end
endmodule

// File: rtl/sar_reg.sv
// Successive-approximation register: trial k owns bit NBITS-1-k.
module sar_reg #(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic             cmp_hi,
    input  logic [NBITS-1:0] apply_vec,
    input  logic [NBITS-1:0] sample_vec,
    output logic [NBITS-1:0] code
);
    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        localparam int B = NBITS - 1 - k;
        always_ff @(posedge clk) begin
            if (rst || load) begin
                code[B] <= 1'b0;
            end else if (adv) begin
                if (apply_vec[k]) begin
                    code[B] <= 1'b1;
                end else if (sample_vec[k] && !cmp_hi) begin
                    code[B] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
    parameter int NBITS        = 10,
    parameter int CONV_CYCLES  = 62,
    parameter int FIRST_TRIAL  = 2,
    parameter int TRIAL_STRIDE = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_en,
    input  logic             start,
    input  logic             flag_clr,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] code,
    output logic             busy,
    output logic             done_flag,
    output logic             irq
);
    import sar_pkg::*;

    sar_state_e       state_q, state_d;
    logic             accept, adv, last, finish;
    logic [NBITS-1:0] apply_vec, sample_vec;

    assign accept = (state_q == ST_IDLE) && start && mc_en;
    assign adv    = (state_q == ST_CONV) && mc_en;
    assign finish = adv && last;

    // next-state logic: START and FINISH transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CONV;
            ST_CONV: if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs: busy, sticky flag, interrupt pulse
    assign busy = (state_q == ST_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= finish;
            if (finish)        done_flag <= 1'b1;
            else if (flag_clr) done_flag <= 1'b0;
        end
    end

    sar_timer #(
        .NBITS       (NBITS),
        .CONV_CYCLES (CONV_CYCLES),
        .FIRST_TRIAL (FIRST_TRIAL),
        .TRIAL_STRIDE(TRIAL_STRIDE)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (adv),
        .last      (last),
        .apply_vec (apply_vec),
        .sample_vec(sample_vec)
    );

    sar_reg #(
        .NBITS(NBITS)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (adv),
        .cmp_hi    (cmp_hi),
        .apply_vec (apply_vec),
        .sample_vec(sample_vec),
        .code      (code)
    );
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
    parameter int NBITS       = 10,
    parameter int CONV_CYCLES = 62
) (
    input logic             clk,
    input logic             rst,
    input logic             mc_en,
    input logic             start,
    input logic             flag_clr,
    input logic [NBITS-1:0] code,
    input logic             busy,
    input logic             done_flag,
    input logic             irq
);
    localparam int LW = $clog2(CONV_CYCLES + 2);
    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst)                         len_q <= '0;
        else if (!busy && start && mc_en) len_q <= '0;
        else if (busy && mc_en)          len_q <= len_q + LW'(1);
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && mc_en) |=> (code == '0 && busy)); // R1
    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (busy && mc_en && len_q == LW'(CONV_CYCLES - 1)) |=> (!busy && irq)); // R5
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
        (busy && len_q < LW'(CONV_CYCLES - 1)) |=> busy); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done_flag && !busy)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !flag_clr) |=> done_flag); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && mc_en)) |=> ($stable(code) && !busy)); // R8
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && !mc_en) |=> ($stable(code) && busy)); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (code == '0 && !busy && !done_flag && !irq)); // R10
endmodule

bind sar_adc_seq sar_adc_seq_chk #(
    .NBITS      (NBITS),
    .CONV_CYCLES(CONV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mc_en    (mc_en),
    .start    (start),
    .flag_clr (flag_clr),
    .code     (code),
    .busy     (busy),
    .done_flag(done_flag),
    .irq      (irq)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
    localparam int NB = 10;
    localparam int CC = 62;

    logic          clk = 1'b0;
    logic          rst, mc_en, start, flag_clr, cmp_hi;
    logic [NB-1:0] code;
    logic          busy, done_flag, irq;
    int            vin;
    int            checks = 0;
    int            fails  = 0;
    bit            finished = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (int'(code) < vin);

    sar_adc_seq u_dut (
        .clk(clk), .rst(rst), .mc_en(mc_en), .start(start),
        .flag_clr(flag_clr), .cmp_hi(cmp_hi), .code(code),
        .busy(busy), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int expect_code(input int v);
        if (v <= 0) return 0;
        if (v > 1024) return 1023;
        return v - 1;
    endfunction

    // one conversion; gap inserts a disabled clock before each enabled edge
    task automatic run_conv(input int v, input bit gap, input bit dup_start, input bit clr_end);
        int  ex;
        int  prev;
        bit  fl0;
        ex   = expect_code(v);
        vin  = v;
        fl0  = done_flag;
        start = 1'b1; mc_en = 1'b1;
        tick();
        start = 1'b0;
        chk(code == 0 && busy, "R1 start clears", int'(code), 0);
        chk(done_flag == fl0, "R7 start keeps flag", int'(done_flag), int'(fl0));
        for (int e = 1; e <= CC; e++) begin
            if (gap) begin
                mc_en = 1'b0;
                prev  = int'(code);
                tick();
                chk(int'(code) == prev && busy, "R9 frozen", int'(code), prev);
            end
            mc_en = 1'b1;
            if (dup_start && e == 30) start = 1'b1;
            if (clr_end && e == CC)   flag_clr = 1'b1;
            tick();
            start = 1'b0; flag_clr = 1'b0;
            for (int k = 0; k < NB; k++) begin
                if (e == 2 + 6 * k) begin
                    int pre = (k == 0) ? 0 : ((ex >> (NB - k)) << (NB - k));
                    chk(int'(code) == (pre | (1 << (NB - 1 - k))), "R2 trial apply",
                        int'(code), pre | (1 << (NB - 1 - k)));
                end
                if (e == 3 + 6 * k) begin
                    int pre = (ex >> (NB - 1 - k)) << (NB - 1 - k);
                    chk(int'(code) == pre, "R4 trial prefix", int'(code), pre);
                end
            end
            if (e == CC - 1) chk(busy && !irq, "R5 still busy", int'(busy), 1);
            if (e == CC) begin
                chk(!busy, "R5 ends at 62", int'(busy), 0);
                chk(irq && done_flag, "R6 irq and flag", int'({irq, done_flag}), 3);
                chk(int'(code) == ex, "R3 result", int'(code), ex);
            end
        end
        mc_en = 1'b0;
        tick();
        chk(!irq, "R6 irq one clock", int'(irq), 0);
        chk(int'(code) == ex && !busy, "R3 result held", int'(code), ex);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int held;
        rst = 1'b1; mc_en = 1'b0; start = 1'b0; flag_clr = 1'b0; vin = 0;
        tick(); tick();
        rst = 1'b0;
        chk(code == 0 && !busy && !done_flag && !irq, "R10 reset state", int'(code), 0);

        // full input sweep, R3/R4 main function
        for (int v = 0; v <= 1024; v++) begin
            run_conv(v, (v % 97) == 5, (v % 131) == 7, 1'b0);
        end

        // R8: start without machine-cycle enable ignored
        held = int'(code);
        start = 1'b1; mc_en = 1'b0;
        tick();
        start = 1'b0;
        tick();
        chk(!busy && int'(code) == held, "R8 start without enable", int'(busy), 0);

        // R7: clear, then set-wins on coincident clear
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk(!done_flag, "R7 clear", int'(done_flag), 0);
        tick();
        chk(!done_flag, "R7 stays clear", int'(done_flag), 0);
        run_conv(700, 1'b0, 1'b1, 1'b1);
        chk(done_flag, "R7 set wins", int'(done_flag), 1);

        // R10: reset in mid-conversion
        vin = 900; start = 1'b1; mc_en = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        chk(busy && code != 0, "R10 running before reset", int'(busy), 1);
        rst = 1'b1;
        tick();
        rst = 1'b0; mc_en = 1'b0;
        chk(code == 0 && !busy && !done_flag && !irq, "R10 mid reset", int'(code), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule